// File: doc/BRIEF.md
# Card Information Structure Store Controller

This block owns the 512-byte card information structure store of a 16-bit PC Card slave. During boot a local DSP-side port writes the whole store, byte by byte. It then sets a done flag to mark the contents valid. The local side has no way to read the store back. The host reads the store through attribute memory read cycles. It has no path to write the store.

Each host read stretches its own bus cycle. The block pulls the active-low wait output for a fixed number of clocks, drives the byte, and only then lets the host finish. The host may read at any time, including during loading. Until the done flag is set, every read returns a blank byte. The contents are laid out by the loader as one primary structure shared by all functions, followed by one secondary structure for each of up to three card functions. The controller does not interpret that layout.

The host's card reset clears the done flag, which opens the store to local writes again. Once the flag is set, the store is locked against further local writes.

Top module: `cis_store_ctrl`

## Requirements
- R1: When the done flag is clear, a local write (`loc_we` high at a clock edge) stores `loc_wdata` at byte index `loc_idx` (0..511).
- R2: A host read is decoded when `host_ce1_n` or `host_ce2_n` is low, `host_reg_n` is low, `host_oe_n` is low, `host_we_n` is high, `host_addr[0]` is 0 and `host_addr[11:10]` is 0. The byte at index `host_addr[9:1]` is returned on `host_data[7:0]`, and `host_data[15:8]` reads 0x00.
- R3: `host_wait_n` goes low at the first clock edge that sees a decoded read. It stays low for exactly 2 clocks, provided the read continues.
- R4: `host_data_oe` rises one clock before `host_wait_n` is released. It stays high while the read remains decoded, and falls at the first edge where the read is no longer decoded. After reset, wait is high and the bus is not driven.
- R5: While the done flag is clear, every host read returns 0xFF, including reads made while loading is in progress.
- R6: A pulse on `loc_done_set` sets the done flag, and the flag stays set until a card reset.
- R7: Once the done flag is set, local writes leave the store unchanged.
- R8: `card_reset` clears the done flag at the next edge and abandons any read in progress. Stored bytes are kept, and local writes are accepted again.
- R9: A host attribute write cycle (`host_we_n` low) neither stretches the cycle nor drives the bus, and it leaves the store unchanged.
- R10: An access is not decoded, so that wait stays high and the bus stays undriven, if it targets common memory (`host_reg_n` high), enables neither card half, uses an odd address, or uses an address with `host_addr[11:10]` nonzero.
- R11: If the read strobe is withdrawn while wait is still low, the next edge releases wait and leaves the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_reset | input | 1 | Host card reset, active high, sampled on the clock |
| loc_we | input | 1 | Local store write strobe |
| loc_idx | input | 9 | Local write byte index |
| loc_wdata | input | 8 | Local write byte |
| loc_done_set | input | 1 | Local pulse marking loading complete |
| host_ce1_n | input | 1 | Card enable, low half |
| host_ce2_n | input | 1 | Card enable, high half |
| host_reg_n | input | 1 | Low selects attribute space |
| host_oe_n | input | 1 | Host read strobe, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_addr | input | 12 | Host byte address |
| host_data | output | 16 | Read data toward the host |
| host_data_oe | output | 1 | High while the block drives the data bus |
| host_wait_n | output | 1 | Active-low cycle stretch |

## Verification
The bench loads every byte with a computed pattern and reads back all 512 indices through both card enables. Each read is timed clock by clock. A design that released wait before the data was driven, or that stretched the cycle for the wrong length, would fail at the exact clock where the timing goes wrong. Reads issued before the done flag is set, including one in the middle of loading, must return the blank byte; a design that leaked stored contents early would show them there. Late local writes, host write cycles, strobes withdrawn early, and the undecoded access forms are each followed by a readback or a port observation. Together these expose a lock that does not hold, a decode that is too loose, or a cycle left hanging. A card reset must reopen the store for writing while keeping the untouched bytes.

// File: rtl/cis_store_pkg.sv
package cis_store_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_BUSY = 2'd1,
    RD_HOLD = 2'd2
  } rd_state_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/cis_store_mem.sv
module cis_store_mem #(
  parameter int DEPTH = 512,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_reset,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             done_set,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             done
);
  logic [7:0] store [DEPTH];
  logic       done_q, done_d;
  logic       wr_ok;

  assign wr_ok = wr_en && !done_q;

  always_comb begin
    done_d = done_q;
    if (card_reset)    done_d = 1'b0;
    else if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) store[wr_idx] <= wr_byte;
  end

  assign rd_byte = store[rd_idx];
  assign done    = done_q;
endmodule

// File: rtl/cis_store_host_rd.sv
module cis_store_host_rd
  import cis_store_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int IDX_W     = 9,
  parameter int WAIT_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_reset,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              reg_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              store_valid,
  input  logic [7:0]        rd_byte,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [15:0]       data,
  output logic              data_oe,
  output logic              wait_n
);
  localparam int CNT_W = $clog2(WAIT_CLKS + 1);
  localparam int HI_W  = ADDR_W - IDX_W - 1;
  localparam logic [CNT_W-1:0] DRIVE_AT   = CNT_W'(WAIT_CLKS - 2);
  localparam logic [CNT_W-1:0] RELEASE_AT = CNT_W'(WAIT_CLKS - 1);

  rd_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       dat_q, dat_d;
  logic             oe_q, oe_d;
  logic             wait_q, wait_d;
  logic             hit;

  assign hit = (!ce1_n || !ce2_n) && !reg_n && !oe_n && we_n && !addr[0]
               && (addr[ADDR_W-1 -: HI_W] == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    dat_d  = dat_q;
    oe_d   = oe_q;
    wait_d = wait_q;
    unique case (st_q)
      RD_IDLE: begin
        if (hit) begin
          st_d   = RD_BUSY;
          cnt_d  = '0;
          idx_d  = addr[IDX_W:1];
          wait_d = 1'b0;
        end
      end
      RD_BUSY: begin
        if (!hit) begin
          st_d   = RD_IDLE;
          wait_d = 1'b1;
          oe_d   = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == DRIVE_AT) begin
            oe_d  = 1'b1;
            dat_d = store_valid ? rd_byte : BLANK_BYTE;
          end
          if (cnt_q == RELEASE_AT) begin
            st_d   = RD_HOLD;
            wait_d = 1'b1;
          end
        end
      end
      RD_HOLD: begin
        if (!hit) begin
          st_d = RD_IDLE;
          oe_d = 1'b0;
        end
      end
      default: begin
        st_d   = RD_IDLE;
        wait_d = 1'b1;
        oe_d   = 1'b0;
      end
    endcase
    if (card_reset) begin
      st_d   = RD_IDLE;
      wait_d = 1'b1;
      oe_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      oe_q   <= 1'b0;
      wait_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      dat_q  <= dat_d;
      oe_q   <= oe_d;
      wait_q <= wait_d;
    end
  end

  assign rd_idx  = idx_q;
  assign data    = {8'h00, dat_q};
  assign data_oe = oe_q;
  assign wait_n  = wait_q;
endmodule

// File: rtl/cis_store_ctrl.sv
module cis_store_ctrl #(
  parameter int DEPTH     = 512,
  parameter int ADDR_W    = 12,
  parameter int WAIT_CLKS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     card_reset,
  input  logic                     loc_we,
  input  logic [$clog2(DEPTH)-1:0] loc_idx,
  input  logic [7:0]               loc_wdata,
  input  logic                     loc_done_set,
  input  logic                     host_ce1_n,
  input  logic                     host_ce2_n,
  input  logic                     host_reg_n,
  input  logic                     host_oe_n,
  input  logic                     host_we_n,
  input  logic [ADDR_W-1:0]        host_addr,
  output logic [15:0]              host_data,
  output logic                     host_data_oe,
  output logic                     host_wait_n
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic             store_done;

  cis_store_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_reset (card_reset),
    .wr_en      (loc_we),
    .wr_idx     (loc_idx),
    .wr_byte    (loc_wdata),
    .done_set   (loc_done_set),
    .rd_idx     (rd_idx),
    .rd_byte    (rd_byte),
    .done       (store_done)
  );

  cis_store_host_rd #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAIT_CLKS(WAIT_CLKS)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .card_reset  (card_reset),
    .ce1_n       (host_ce1_n),
    .ce2_n       (host_ce2_n),
    .reg_n       (host_reg_n),
    .oe_n        (host_oe_n),
    .we_n        (host_we_n),
    .addr        (host_addr),
    .store_valid (store_done),
    .rd_byte     (rd_byte),
    .rd_idx      (rd_idx),
    .data        (host_data),
    .data_oe     (host_data_oe),
    .wait_n      (host_wait_n)
  );
endmodule

// File: rtl/cis_store_ctrl_chk.sv
module cis_store_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              card_reset,
  input logic              host_ce1_n,
  input logic              host_ce2_n,
  input logic              host_reg_n,
  input logic              host_oe_n,
  input logic              host_we_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [15:0]       host_data,
  input logic              host_data_oe,
  input logic              host_wait_n,
  input logic              store_done
);
  logic hit;
  assign hit = (!host_ce1_n || !host_ce2_n) && !host_reg_n && !host_oe_n && host_we_n
               && !host_addr[0] && (host_addr[ADDR_W-1:ADDR_W-2] == 2'b00);

  AST_WAIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) && !$past(hit, 2) && !$past(card_reset)) |-> !host_wait_n); // R3

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_wait_n) && hit && !card_reset) |=> !host_wait_n); // R3

  AST_DRIVEN_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_wait_n) && $past(hit) && !$past(card_reset)) |-> $past(host_data_oe)); // R4

  AST_NO_DRIVE_UNDECODED: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !host_data_oe); // R10

  AST_BLANK_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_data_oe) && !$past(store_done)) |-> (host_data[7:0] == 8'hFF)); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> (host_data[15:8] == 8'h00)); // R2

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    card_reset |=> !store_done); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done && !card_reset) |=> store_done); // R6
endmodule

bind cis_store_ctrl cis_store_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .card_reset   (card_reset),
  .host_ce1_n   (host_ce1_n),
  .host_ce2_n   (host_ce2_n),
  .host_reg_n   (host_reg_n),
  .host_oe_n    (host_oe_n),
  .host_we_n    (host_we_n),
  .host_addr    (host_addr),
  .host_data    (host_data),
  .host_data_oe (host_data_oe),
  .host_wait_n  (host_wait_n),
  .store_done   (store_done)
);

// File: tb/cis_store_ctrl_test.sv
module cis_store_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, card_reset;
  logic        loc_we, loc_done_set;
  logic [8:0]  loc_idx;
  logic [7:0]  loc_wdata;
  logic        host_ce1_n, host_ce2_n, host_reg_n, host_oe_n, host_we_n;
  logic [11:0] host_addr;
  logic [15:0] host_data;
  logic        host_data_oe, host_wait_n;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cis_store_ctrl uut (
    .clk(clk), .rst_n(rst_n), .card_reset(card_reset),
    .loc_we(loc_we), .loc_idx(loc_idx), .loc_wdata(loc_wdata), .loc_done_set(loc_done_set),
    .host_ce1_n(host_ce1_n), .host_ce2_n(host_ce2_n), .host_reg_n(host_reg_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n), .host_addr(host_addr),
    .host_data(host_data), .host_data_oe(host_data_oe), .host_wait_n(host_wait_n)
  );

  function automatic logic [7:0] pat_a(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat_b(input int i);
    return 8'((i * 11 + 200) & 255) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    host_ce1_n = 1'b1; host_ce2_n = 1'b1; host_reg_n = 1'b1;
    host_oe_n  = 1'b1; host_we_n  = 1'b1; host_addr  = '0;
  endtask

  task automatic loc_write(input int i, input logic [7:0] d);
    @(negedge clk);
    loc_we = 1'b1; loc_idx = 9'(i); loc_wdata = d;
    @(negedge clk);
    loc_we = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); loc_done_set = 1'b1;
    @(negedge clk); loc_done_set = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, input bit use_ce2, input logic [7:0] exp, input string req);
    @(negedge clk);
    host_addr = a; host_reg_n = 1'b0; host_oe_n = 1'b0;
    if (use_ce2) host_ce2_n = 1'b0; else host_ce1_n = 1'b0;
    @(negedge clk);
    chk(host_wait_n == 1'b0, "R3 wait low after first edge", int'(host_wait_n), 0);
    chk(host_data_oe == 1'b0, "R4 not yet driven", int'(host_data_oe), 0);
    @(negedge clk);
    chk(host_wait_n == 1'b0, "R3 wait low second clock", int'(host_wait_n), 0);
    chk(host_data_oe == 1'b1, "R4 driven before release", int'(host_data_oe), 1);
    chk(host_data == {8'h00, exp}, req, int'(host_data), int'({8'h00, exp}));
    @(negedge clk);
    chk(host_wait_n == 1'b1, "R3 wait released after two clocks", int'(host_wait_n), 1);
    chk(host_data_oe == 1'b1 && host_data == {8'h00, exp}, "R4 data held", int'(host_data), int'({8'h00, exp}));
    bus_idle();
    @(negedge clk);
    chk(host_data_oe == 1'b0, "R4 bus released after strobe", int'(host_data_oe), 0);
  endtask

  task automatic expect_quiet(input string req);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(host_wait_n == 1'b1 && host_data_oe == 1'b0, req,
          int'({host_wait_n, host_data_oe}), 2);
    end
    bus_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; card_reset = 1'b0;
    loc_we = 1'b0; loc_done_set = 1'b0; loc_idx = '0; loc_wdata = '0;
    bus_idle();
    repeat (3) @(negedge clk);
    chk(host_wait_n == 1'b1 && host_data_oe == 1'b0, "R4 reset state",
        int'({host_wait_n, host_data_oe}), 2);
    rst_n = 1'b1;

    // R1 load all bytes; R5 reads during load are blank
    for (int i = 0; i < 512; i++) begin
      loc_write(i, pat_a(i));
      if (i == 256) host_read(12'(2 * 10), 1'b0, 8'hFF, "R5 blank during load");
    end
    host_read(12'(2 * 300), 1'b1, 8'hFF, "R5 blank before done");

    pulse_done(); // R6
    for (int i = 0; i < 512; i++)
      host_read(12'(2 * i), i[0], pat_a(i), "R2 R1 readback of loaded byte");

    // R7 writes after done ignored
    for (int i = 0; i < 8; i++) loc_write(i * 60, pat_b(i * 60));
    for (int i = 0; i < 8; i++) host_read(12'(2 * i * 60), 1'b0, pat_a(i * 60), "R7 locked store unchanged");
    host_read(12'(2 * 7), 1'b0, pat_a(7), "R6 done still set");

    // R9 host write cycles
    @(negedge clk); host_ce1_n = 1'b0; host_reg_n = 1'b0; host_we_n = 1'b0; host_addr = 12'h020;
    expect_quiet("R9 write cycle not stretched");
    @(negedge clk); host_ce1_n = 1'b0; host_reg_n = 1'b0; host_we_n = 1'b0; host_oe_n = 1'b0; host_addr = 12'h020;
    expect_quiet("R9 both strobes not decoded");
    host_read(12'h020, 1'b0, pat_a(16), "R9 store unchanged by host write");

    // R10 undecoded forms
    @(negedge clk); host_ce1_n = 1'b0; host_oe_n = 1'b0; host_addr = 12'h040;
    expect_quiet("R10 common memory");
    @(negedge clk); host_reg_n = 1'b0; host_oe_n = 1'b0; host_addr = 12'h040;
    expect_quiet("R10 no card enable");
    @(negedge clk); host_ce1_n = 1'b0; host_reg_n = 1'b0; host_oe_n = 1'b0; host_addr = 12'h041;
    expect_quiet("R10 odd address");
    @(negedge clk); host_ce2_n = 1'b0; host_reg_n = 1'b0; host_oe_n = 1'b0; host_addr = 12'h440;
    expect_quiet("R10 address above store");

    // R11 aborted read
    @(negedge clk); host_ce1_n = 1'b0; host_reg_n = 1'b0; host_oe_n = 1'b0; host_addr = 12'h010;
    @(negedge clk);
    chk(host_wait_n == 1'b0, "R11 wait asserted before abort", int'(host_wait_n), 0);
    host_oe_n = 1'b1;
    @(negedge clk);
    chk(host_wait_n == 1'b1 && host_data_oe == 1'b0, "R11 abort releases",
        int'({host_wait_n, host_data_oe}), 2);
    bus_idle();
    host_read(12'h010, 1'b0, pat_a(8), "R11 next read normal");

    // R8 card reset
    @(negedge clk); card_reset = 1'b1;
    @(negedge clk); card_reset = 1'b0;
    host_read(12'h064, 1'b0, 8'hFF, "R8 done cleared blanks reads");
    for (int i = 0; i < 4; i++) loc_write(100 + i, pat_b(100 + i));
    pulse_done();
    for (int i = 0; i < 4; i++) host_read(12'(2 * (100 + i)), 1'b1, pat_b(100 + i), "R8 writes accepted after reset");
    host_read(12'(2 * 99), 1'b0, pat_a(99), "R8 content kept across reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule